// File: doc/BRIEF.md
# Calibration-Table Linear Interpolator

This block turns a pair of converter samples into a calibrated quantity. The difference between a raw sample and an offset sample is scaled by a fixed rational factor. The scaled value is then located in a sorted calibration table of (x, y) breakpoints held in a parameter-initialised ROM. The output is the straight-line value between the two breakpoints that bracket the input. The multiply is kept at double width so that it cannot overflow, and the divide runs in a bit-serial restoring divider.

The table layout has a fixed meaning. Entry 0 holds only the upper limit of the accepted band. Entries 1 to N-1 are the breakpoints in strictly increasing x order, and entry 1 is also the lower limit. A caller pulses start with the two samples and waits for the one-cycle done pulse. At that point either a result or an error flag with a fixed substitute value is presented. The outputs then hold until the next done.

Top module: `lerp_table_interp`

## Requirements
- R1: Raw and offset are unsigned 12-bit codes. The scaled input is v = 101750 × (raw − offset) / 10, formed in signed arithmetic, so an offset above the raw sample gives a negative v.
- R2: v is out of band when v > x[0] or v < x[1]. Both limits are inclusive, so v equal to x[0] or to x[1] is accepted.
- R3: The segment index i starts at 1 and advances while x[i] < v. Interpolation uses entries i−1 and i. A v equal to any breakpoint x[k] with k ≥ 1 returns exactly y[k].
- R4: The output is y[i−1] + (y[i] − y[i−1]) × (v − x[i−1]) / (x[i] − x[i−1]). The product is exact at double width, and the quotient is truncated toward zero, which also applies on segments where y falls.
- R5: On any error, err_o is 1 and result_o is −1000. On a valid result, err_o is 0.
- R6: If the search reaches the last entry and x[N−1] is still below v, the block reports an error and reads nothing past the table.
- R7: Each accepted start yields exactly one done_o pulse, one cycle wide. err_o and result_o hold their values until the next done_o.
- R8: A start_i pulse that arrives while a computation is in progress is ignored. It does not change the pending result and does not produce a second done_o.
- R9: After reset, done_o, err_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to convert the current samples |
| raw_i | input | 12 | Raw converter sample (unsigned) |
| offset_i | input | 12 | Offset converter sample (unsigned) |
| done_o | output | 1 | One-cycle pulse when result_o and err_o are valid |
| err_o | output | 1 | 1 when the last conversion was rejected |
| result_o | output | 32 | Interpolated value (signed), or −1000 on error |

## Verification
The assertions check the following on every cycle:
- done stays a single-cycle pulse.
- An error always carries the substitute value.
- The search comes to rest on a segment whose upper x is not below the input.
- The divider's remainder ends below its divisor.
- A valid result lies between the two y values of the chosen segment.
- A start seen while busy never restarts the sequence.

Only the bench's scenarios can show the exact interpolated numbers and the truncation on a falling segment. They alone cover the inclusive band edges, the exhausted-search error on a table whose top breakpoint lies under the band limit, and that a start ignored mid-run leaves the original answer in place.

// File: rtl/lerp_pkg.sv
package lerp_pkg;
  localparam int WORD_W = 32;
  typedef logic signed [WORD_W-1:0] word_t;

  // Default calibration table: entry 0 is the band ceiling, 1..N-1 ascending.
  localparam int DEF_N = 8;
  localparam word_t DEF_X [DEF_N] = '{40700000, 0, 4070000, 10175000,
                                      20350000, 30525000, 36630000, 40700000};
  localparam word_t DEF_Y [DEF_N] = '{3650, -500, 200, 900,
                                      2100, 3000, 3700, 3650};

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCALE, ST_CHECK, ST_SEARCH, ST_MUL, ST_DIV
  } state_t;
endpackage

// File: rtl/lerp_rom.sv
module lerp_rom
  import lerp_pkg::*;
#(
  parameter int    N = DEF_N,
  parameter word_t TX [N] = DEF_X,
  parameter word_t TY [N] = DEF_Y,
  localparam int   IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IW-1:0] hi_idx,
  input  logic [IW-1:0] lo_idx,
  output word_t         x_hi,
  output word_t         y_hi,
  output word_t         x_lo,
  output word_t         y_lo
);
  // Two asynchronous read ports over a constant table.
  always_comb begin
    x_hi = '0;
    y_hi = '0;
    x_lo = '0;
    y_lo = '0;
    if (int'(hi_idx) < N) begin
      x_hi = TX[hi_idx];
      y_hi = TY[hi_idx];
    end
    if (int'(lo_idx) < N) begin
      x_lo = TX[lo_idx];
      y_lo = TY[lo_idx];
    end
  end
endmodule

// File: rtl/lerp_div.sv
module lerp_div #(
  parameter int  NUM_W = 66,
  parameter int  DEN_W = 33,
  localparam int CW    = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q;
  logic             done_q;
  logic [DEN_W:0]   trial;
  logic             take;

  assign trial = {rem_q[DEN_W-1:0], num_q[NUM_W-1]};
  assign take  = (trial >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        num_q  <= num_i;
        den_q  <= den_i;
        rem_q  <= '0;
        quo_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= take ? (trial - {1'b0, den_q}) : trial;
        quo_q <= {quo_q[NUM_W-2:0], take};
        num_q <= num_q << 1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NUM_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R4
  div_rem_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/lerp_table_interp.sv
module lerp_table_interp
  import lerp_pkg::*;
#(
  parameter int    RAW_W     = 12,
  parameter int    SCALE_NUM = 101750,
  parameter int    SCALE_DEN = 10,
  parameter int    ERR_VALUE = -1000,
  parameter int    TAB_N     = DEF_N,
  parameter word_t TAB_X [TAB_N] = DEF_X,
  parameter word_t TAB_Y [TAB_N] = DEF_Y
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [RAW_W-1:0] raw_i,
  input  logic [RAW_W-1:0] offset_i,
  output logic             done_o,
  output logic             err_o,
  output logic [31:0]      result_o
);
  localparam int IW    = (TAB_N > 1) ? $clog2(TAB_N) : 1;
  localparam int SCALE = SCALE_NUM / SCALE_DEN;
  localparam int MAG_W = WORD_W + 1;
  localparam int NUM_W = 2 * MAG_W;

  state_t                  st;
  logic signed [RAW_W:0]   diff_q;
  word_t                   val_q, base_q, ylo_q, yhi_q, res_q;
  logic [IW-1:0]           idx_q;
  logic                    neg_q, done_q, err_q;
  logic [IW-1:0]           rd_hi, rd_lo;
  word_t                   x_hi, y_hi, x_lo, y_lo;
  logic signed [MAG_W-1:0] dy, dv, dx;
  logic [NUM_W-1:0]        prod;
  logic [MAG_W-1:0]        dx_mag;
  logic                    div_go, div_done;
  logic [NUM_W-1:0]        quo;

  function automatic logic [MAG_W-1:0] mag(input logic signed [MAG_W-1:0] a);
    return a[MAG_W-1] ? MAG_W'(-a) : MAG_W'(a);
  endfunction

  // Band check reads the ceiling (0) and floor (1); otherwise the segment.
  assign rd_hi = (st == ST_CHECK) ? '0 : idx_q;
  assign rd_lo = (st == ST_CHECK) ? IW'(1) : (idx_q - IW'(1));

  lerp_rom #(.N(TAB_N), .TX(TAB_X), .TY(TAB_Y)) u_rom (
    .hi_idx(rd_hi), .lo_idx(rd_lo),
    .x_hi(x_hi), .y_hi(y_hi), .x_lo(x_lo), .y_lo(y_lo)
  );

  always_comb begin
    dy     = {y_hi[WORD_W-1], y_hi} - {y_lo[WORD_W-1], y_lo};
    dv     = {val_q[WORD_W-1], val_q} - {x_lo[WORD_W-1], x_lo};
    dx     = {x_hi[WORD_W-1], x_hi} - {x_lo[WORD_W-1], x_lo};
    prod   = NUM_W'(mag(dy)) * NUM_W'(mag(dv));
    dx_mag = mag(dx);
    div_go = (st == ST_MUL);
  end

  lerp_div #(.NUM_W(NUM_W), .DEN_W(MAG_W)) u_div (
    .clk(clk), .rst(rst), .start_i(div_go),
    .num_i(prod), .den_i(dx_mag),
    .done_o(div_done), .quo_o(quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      diff_q <= '0;
      val_q  <= '0;
      base_q <= '0;
      ylo_q  <= '0;
      yhi_q  <= '0;
      res_q  <= '0;
      idx_q  <= '0;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          diff_q <= $signed({1'b0, raw_i}) - $signed({1'b0, offset_i});
          st     <= ST_SCALE;
        end
        ST_SCALE: begin
          val_q <= word_t'(diff_q) * word_t'(SCALE);
          st    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (val_q > x_hi || val_q < x_lo) begin
            res_q  <= word_t'(ERR_VALUE);
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            idx_q <= IW'(1);
            st    <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (x_hi < val_q) begin
            if (idx_q == IW'(TAB_N - 1)) begin
              res_q  <= word_t'(ERR_VALUE);
              err_q  <= 1'b1;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            st <= ST_MUL;
          end
        end
        ST_MUL: begin
          base_q <= y_lo;
          neg_q  <= dy[MAG_W-1] ^ dv[MAG_W-1] ^ dx[MAG_W-1];
          ylo_q  <= (y_lo < y_hi) ? y_lo : y_hi;
          yhi_q  <= (y_lo < y_hi) ? y_hi : y_lo;
          st     <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          res_q  <= neg_q ? (base_q - word_t'(quo)) : (base_q + word_t'(quo));
          err_q  <= 1'b0;
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = res_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R5
  err_value_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && err_q) |-> (res_q == word_t'(ERR_VALUE)));
  // R4
  result_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !err_q) |-> (res_q >= ylo_q && res_q <= yhi_q));
  // R3
  segment_top_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MUL) |-> (val_q <= x_hi));
  // R3
  segment_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MUL && idx_q > IW'(1)) |-> (val_q > x_lo));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && start_i) |=> (st != ST_SCALE));
endmodule

// File: tb/test_lerp_table_interp.sv
module test_lerp_table_interp;
  import lerp_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_a = 1'b0, start_b = 1'b0;
  logic [11:0] raw = '0, off = '0;
  logic        done_a, err_a, done_b, err_b;
  logic [31:0] res_a, res_b;
  int          checks = 0, errors = 0, cyc = 0;

  // Bench copies of the tables; table B has its top breakpoint under the ceiling.
  int XA [8] = '{40700000, 0, 4070000, 10175000, 20350000, 30525000, 36630000, 40700000};
  int XB [8] = '{41615750, 0, 4070000, 10175000, 20350000, 30525000, 36630000, 40700000};
  int YT [8] = '{3650, -500, 200, 900, 2100, 3000, 3700, 3650};
  localparam word_t XB_P [8] = '{41615750, 0, 4070000, 10175000,
                                 20350000, 30525000, 36630000, 40700000};

  always #2 clk = ~clk;

  lerp_table_interp i_lerp_table_interp (
    .clk(clk), .rst(rst), .start_i(start_a), .raw_i(raw), .offset_i(off),
    .done_o(done_a), .err_o(err_a), .result_o(res_a));

  lerp_table_interp #(.TAB_X(XB_P)) i_lerp_table_interp_b (
    .clk(clk), .rst(rst), .start_i(start_b), .raw_i(raw), .offset_i(off),
    .done_o(done_b), .err_o(err_b), .result_o(res_b));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL R7 watchdog: cycles %0d expected below 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic void model(input int w, input int r, input int o,
                                output bit e, output int res);
    longint v = (longint'(101750) * longint'(r - o)) / 10;
    longint xs [8];
    int i;
    for (int k = 0; k < 8; k++) xs[k] = (w != 0) ? XB[k] : XA[k];
    e = 1'b1;
    res = -1000;
    if (v > xs[0] || v < xs[1]) return;
    i = 1;
    while (xs[i] < v) begin
      if (i == 7) return;
      i++;
    end
    e = 1'b0;
    res = int'(longint'(YT[i-1]) +
               (longint'(YT[i] - YT[i-1]) * (v - xs[i-1])) / (xs[i] - xs[i-1]));
  endfunction

  function automatic bit dn(input int w);
    return (w != 0) ? done_b : done_a;
  endfunction

  task automatic run(input int w, input int r, input int o, input string req);
    bit e, got;
    int ex;
    model(w, r, o, e, ex);
    @(negedge clk);
    raw = 12'(r);
    off = 12'(o);
    if (w != 0) start_b = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    start_b = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (dn(w)) begin got = 1'b1; break; end
      @(negedge clk);
    end
    checks++;
    if (!got || ((w != 0) ? err_b : err_a) != e || ((w != 0) ? res_b : res_a) != 32'(ex)) begin
      errors++;
      $display("FAIL %s raw=%0d off=%0d: done=%0d err=%0d res=%0d expected err=%0d res=%0d",
               req, r, o, got, (w != 0) ? err_b : err_a,
               $signed((w != 0) ? res_b : res_a), e, ex);
    end
    @(negedge clk);
    checks++;
    if (dn(w)) begin
      errors++;
      $display("FAIL R7 done width: done=1 expected 0 one cycle after pulse");
    end
  endtask

  initial begin
    bit e;
    int ex, extra;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    checks++;
    if (done_a || err_a || res_a != 32'd0 || done_b || err_b || res_b != 32'd0) begin
      errors++;
      $display("FAIL R9 reset: done=%0d err=%0d res=%0d expected 0 0 0", done_a, err_a, res_a);
    end
    // R4 sweep over the raw code with zero offset
    for (int r = 0; r < 4096; r += 13) run(0, r, 0, "R4");
    // R1 offset sweep, including offsets above the raw sample
    for (int o = 0; o < 4096; o += 41) run(0, 2500, o, "R1");
    run(0, 4095, 95, "R1");
    // R2 inclusive band edges
    run(0, 4000, 0, "R2");
    run(0, 4001, 0, "R2");
    run(0, 0, 0, "R2");
    run(0, 100, 101, "R2");
    // R3 exact breakpoints
    run(0, 400, 0, "R3");
    run(0, 1000, 0, "R3");
    run(0, 2000, 0, "R3");
    run(0, 3000, 0, "R3");
    run(0, 3600, 0, "R3");
    // R4 falling segment, truncation toward zero
    run(0, 3601, 0, "R4");
    run(0, 3800, 0, "R4");
    run(0, 3999, 0, "R4");
    // R5 error substitute value
    run(0, 4095, 0, "R5");
    // R6 search exhausted on table B
    run(1, 4050, 0, "R6");
    run(1, 4090, 0, "R6");
    run(1, 4000, 0, "R6");
    // R8 start while busy is ignored
    model(0, 1500, 0, e, ex);
    @(negedge clk);
    raw = 12'd1500; off = 12'd0; start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    repeat (5) @(negedge clk);
    raw = 12'd3000; start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done_a) break;
      @(negedge clk);
    end
    checks++;
    if (!done_a || err_a != e || res_a != 32'(ex)) begin
      errors++;
      $display("FAIL R8 result: done=%0d res=%0d expected res=%0d", done_a, $signed(res_a), ex);
    end
    extra = 0;
    repeat (150) begin
      @(negedge clk);
      if (done_a) extra++;
    end
    checks++;
    if (extra != 0) begin
      errors++;
      $display("FAIL R8 extra done pulses: %0d expected 0", extra);
    end
    // R7 outputs hold after done
    checks++;
    if (res_a != 32'(ex) || err_a != e) begin
      errors++;
      $display("FAIL R7 hold: res=%0d expected %0d", $signed(res_a), ex);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule